// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block looks after parity for one agent on a shared bus. The bus has a 32-bit multiplexed address/data path and a 4-bit command/byte-enable path. When the agent drives the address/data lines in a clock, the block registers what was driven. In the following clock it presents the even-parity bit together with an output enable, so the parity line turns around exactly as the data lines do.

When the agent is receiving, the block registers the observed address/data and command/byte-enable values. In the next clock it compares them with the incoming parity bit. A mismatch is reported in the clock after that, which is two clocks after the data itself. A mismatch in a data phase pulls the active-low data parity error output low for one clock. This happens only when parity-error response is enabled. A mismatch in an address phase asks the open-drain system error line to be pulled low for one clock. This happens only when system-error reporting is enabled. The line is never driven high.

Two sticky status bits record detected parity errors and signalled system errors. Software clears them by writing a 1 to the matching bit.

Top module: `bus_parity_unit`

## Requirements
- R1: In the clock after the agent drives `ad_in`/`cbe_in` (`ad_oe`=1), `par_out` equals the XOR of all 32 `ad_in` bits and all 4 `cbe_in` bits from that earlier clock. The 37 lines therefore carry an even number of ones, and every `ad_in` bit counts.
- R2: `par_oe` equals `ad_oe` delayed by one clock.
- R3: When a receive phase (`phase_vld`=1, `phase_is_addr`=0, `ad_oe`=0) is seen in clock T and `par_in` in clock T+1 makes the 37-line count odd, `perr_n` is 0 in clock T+2 only, provided `cmd_par_resp`=1 in clock T+1.
- R4: With `cmd_par_resp`=0, a data-phase mismatch leaves `perr_n` at 1.
- R5: Every detected mismatch, in either phase kind and whatever the enables, sets status bit 0 (detected parity error), visible on `status[0]` from clock T+2.
- R6: A mismatch in an address phase (`phase_is_addr`=1) with `cmd_serr_en`=1 in clock T+1 makes `serr_pull` 1 in clock T+2 only. It also sets status bit 1 (signalled system error), and `perr_n` stays 1.
- R7: With `cmd_serr_en`=0, an address-phase mismatch leaves `serr_pull` at 0 and status bit 1 at 0, while status bit 0 is still set.
- R8: A clock with `stat_wr`=1 clears each status bit whose `stat_wdata` bit is 1 and leaves the others alone. A set in the same clock wins over the clear.
- R9: Phases where the agent drives (`ad_oe`=1), or with `phase_vld`=0, are never checked and cause no report and no status change.
- R10: After reset `perr_n`=1, `serr_pull`=0, `par_oe`=0 and `status`=0.
- R11: Correct parity produces no report in either phase kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_in | input | 32 | Address/data lines as driven or observed this clock |
| cbe_in | input | 4 | Command/byte-enable lines this clock |
| par_in | input | 1 | Parity line as observed this clock |
| ad_oe | input | 1 | Agent drives address/data this clock |
| phase_vld | input | 1 | This clock is an address or data phase |
| phase_is_addr | input | 1 | The valid phase is an address phase |
| cmd_par_resp | input | 1 | Command bit: report data parity errors |
| cmd_serr_en | input | 1 | Command bit: report address parity errors on system error |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Write-one-to-clear mask for the status bits |
| par_out | output | 1 | Generated parity bit for the previous clock's data |
| par_oe | output | 1 | Parity line output enable |
| perr_n | output | 1 | Data parity error, active low |
| serr_pull | output | 1 | Pull the open-drain system error line low |
| status | output | 2 | Sticky status: bit 0 parity detected, bit 1 system error signalled |

## Verification
A status bit can be set by a new error in the same clock that a software write clears it. The bench provokes this by strobing a write with both mask bits set in clock T+1 of an erroneous phase. That is the clock whose ending edge also records the error. The bench judges the result by reading `status` in T+2, where the bit must remain 1, and then clearing it with a later write. A second overlap is an error report in one phase coinciding with the latching of the next phase. The back-to-back data-phase test checks that both reports appear on consecutive clocks.

// File: rtl/bpar_pkg.sv
// Shared constants for the bus parity unit.
// Assumes the status register is two bits wide, with fixed bit positions.
package bpar_pkg;
    localparam int STAT_W   = 2;
    localparam int STAT_DPE = 0;  // detected parity error
    localparam int STAT_SSE = 1;  // signalled system error
endpackage

// File: rtl/bpar_gen.sv
// Front stage: registers one bus clock of address/data, command lines and
// phase qualifiers, then presents parity and its output enable one clock later.
// Assumes ad_in/cbe_in hold the full bus value whether driven or received.
module bpar_gen #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             ad_oe,
    input  logic             phase_vld,
    input  logic             phase_is_addr,
    output logic             lat_par,
    output logic             lat_chk,
    output logic             lat_addr,
    output logic             par_oe
);
    localparam int LAT_W = AD_W + CBE_W;

    logic [LAT_W-1:0] lat_bus;

    // Capture the bus and qualifiers for use in the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_bus  <= '0;
            lat_chk  <= 1'b0;
            lat_addr <= 1'b0;
            par_oe   <= 1'b0;
        end else begin
            lat_bus  <= {cbe_in, ad_in};
            lat_chk  <= phase_vld && !ad_oe;
            lat_addr <= phase_is_addr;
            par_oe   <= ad_oe;
        end
    end

    // Even parity over every captured line.
    always_comb lat_par = ^lat_bus;

    // R2: parity enable tracks the data enable one clock later
    a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> par_oe);
    a_r2_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |=> !par_oe);
    // R9: a driven phase is never queued for checking
    a_r9_no_self_check: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> !lat_chk);
endmodule

// File: rtl/bpar_chk.sv
// Checker stage: compares the incoming parity bit with parity of the data
// captured one clock earlier, and registers a one-clock report on the
// data-error or system-error path according to phase kind and enables.
// Assumes enables are sampled in the clock the parity bit arrives.
module bpar_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic lat_par,
    input  logic lat_chk,
    input  logic lat_addr,
    input  logic par_in,
    input  logic cmd_par_resp,
    input  logic cmd_serr_en,
    output logic mism,
    output logic sse_set,
    output logic perr_q,
    output logic serr_q
);
    // Mismatch: odd count of ones across captured lines plus incoming parity.
    always_comb begin
        mism    = lat_chk && (lat_par ^ par_in);
        sse_set = mism && lat_addr && cmd_serr_en;
    end

    // Register the report for exactly one clock per mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
            serr_q <= 1'b0;
        end else begin
            perr_q <= mism && !lat_addr && cmd_par_resp;
            serr_q <= sse_set;
        end
    end

    // R4: data error only reported with the response bit set
    a_r4_resp_gate: assert property (@(posedge clk) disable iff (!rst_n)
        perr_q |-> $past(cmd_par_resp));
    // R7: system error only reported with its enable set
    a_r7_serr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        serr_q |-> $past(cmd_serr_en));
    // R6: one phase never reports on both lines
    a_r6_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        !(perr_q && serr_q));
endmodule

// File: rtl/bpar_status.sv
// Sticky status bits with write-one-to-clear; a set in the same clock as
// a clear wins. Assumes set inputs are single-clock pulses.
module bpar_status
    import bpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpe_set,
    input  logic              sse_set,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    // Gather set and clear masks.
    always_comb begin
        set_vec           = '0;
        set_vec[STAT_DPE] = dpe_set;
        set_vec[STAT_SSE] = sse_set;
        clr_vec           = wr ? wdata : '0;
    end

    // Hold, clear and set the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // R8: a set always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dpe_set |=> status[STAT_DPE]);
    // R8: without set or clear a bit holds
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !dpe_set && !sse_set) |=> $stable(status));
endmodule

// File: rtl/bus_parity_unit.sv
// Top of the parity unit: generation, checking and status for one agent.
// Assumes the pad logic drives par_out when par_oe is 1 and pulls the
// shared system error line low while serr_pull is 1.
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AD_W-1:0]   ad_in,
    input  logic [CBE_W-1:0]  cbe_in,
    input  logic              par_in,
    input  logic              ad_oe,
    input  logic              phase_vld,
    input  logic              phase_is_addr,
    input  logic              cmd_par_resp,
    input  logic              cmd_serr_en,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              par_out,
    output logic              par_oe,
    output logic              perr_n,
    output logic              serr_pull,
    output logic [STAT_W-1:0] status
);
    logic lat_par, lat_chk, lat_addr;
    logic mism, sse_set, perr_q, serr_q;

    bpar_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in),
        .ad_oe(ad_oe), .phase_vld(phase_vld), .phase_is_addr(phase_is_addr),
        .lat_par(lat_par), .lat_chk(lat_chk), .lat_addr(lat_addr),
        .par_oe(par_oe)
    );

    bpar_chk chk_i (
        .clk(clk), .rst_n(rst_n), .lat_par(lat_par), .lat_chk(lat_chk),
        .lat_addr(lat_addr), .par_in(par_in), .cmd_par_resp(cmd_par_resp),
        .cmd_serr_en(cmd_serr_en), .mism(mism), .sse_set(sse_set),
        .perr_q(perr_q), .serr_q(serr_q)
    );

    bpar_status stat_i (
        .clk(clk), .rst_n(rst_n), .dpe_set(mism), .sse_set(sse_set),
        .wr(stat_wr), .wdata(stat_wdata), .status(status)
    );

    // Drive the parity bit and the active-low / open-drain report outputs.
    always_comb begin
        par_out   = lat_par;
        perr_n    = !perr_q;
        serr_pull = serr_q;
    end

    // R5: every report is backed by the detected status bit
    a_r5_perr_status: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> status[STAT_DPE]);
    // R6: system error report is backed by its status bit
    a_r6_serr_status: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pull |-> status[STAT_SSE]);
endmodule

// File: tb/bus_parity_unit_tb_top.sv
module bus_parity_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        par_in = 1'b0;
    logic        ad_oe = 1'b0;
    logic        phase_vld = 1'b0;
    logic        phase_is_addr = 1'b0;
    logic        cmd_par_resp = 1'b0;
    logic        cmd_serr_en = 1'b0;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_wdata = '0;
    logic        par_out, par_oe, perr_n, serr_pull;
    logic [1:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bus_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in),
        .par_in(par_in), .ad_oe(ad_oe), .phase_vld(phase_vld),
        .phase_is_addr(phase_is_addr), .cmd_par_resp(cmd_par_resp),
        .cmd_serr_en(cmd_serr_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n),
        .serr_pull(serr_pull), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_status();
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 2'b11;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = 2'b00;
    endtask

    // One received phase: flip selects 0 none, 1 ad bit, 2 cbe bit, 3 par.
    task automatic rx_phase(input string req, input logic [31:0] ad, input logic [3:0] cbe,
                            input logic is_addr, input int flip, input int bitpos,
                            input logic resp, input logic sen,
                            input logic exp_perr, input logic exp_serr,
                            input logic [1:0] exp_stat);
        logic good;
        good = ^{ad, cbe};
        @(negedge clk);
        cmd_par_resp = resp; cmd_serr_en = sen;
        ad_in = (flip == 1) ? ad ^ (32'h1 << bitpos) : ad;
        cbe_in = (flip == 2) ? cbe ^ (4'h1 << bitpos) : cbe;
        phase_vld = 1'b1; phase_is_addr = is_addr; ad_oe = 1'b0;
        @(negedge clk);
        chk({req, " no early report"}, {30'd0, perr_n, serr_pull}, 32'h2);
        phase_vld = 1'b0; phase_is_addr = 1'b0;
        par_in = (flip == 3) ? ~good : good;
        @(negedge clk);
        chk({req, " perr_n at T+2"}, {31'd0, perr_n}, {31'd0, ~exp_perr});
        chk({req, " serr_pull at T+2"}, {31'd0, serr_pull}, {31'd0, exp_serr});
        chk({req, " status"}, {30'd0, status}, {30'd0, exp_stat});
        @(negedge clk);
        chk({req, " one-clock pulse"}, {30'd0, perr_n, serr_pull}, 32'h2);
        clear_status();
    endtask

    task automatic t_reset();
        chk("R10 perr_n", {31'd0, perr_n}, 32'd1);
        chk("R10 serr_pull", {31'd0, serr_pull}, 32'd0);
        chk("R10 par_oe", {31'd0, par_oe}, 32'd0);
        chk("R10 status", {30'd0, status}, 32'd0);
    endtask

    task automatic t_generate(input logic [31:0] ad, input logic [3:0] cbe);
        @(negedge clk);
        ad_in = ad; cbe_in = cbe; ad_oe = 1'b1; phase_vld = 1'b1;
        @(negedge clk);
        chk("R1 par_out", {31'd0, par_out}, {31'd0, ^{ad, cbe}});
        chk("R2 par_oe high", {31'd0, par_oe}, 32'd1);
        ad_oe = 1'b0; phase_vld = 1'b0;
        @(negedge clk);
        chk("R2 par_oe low", {31'd0, par_oe}, 32'd0);
        chk("R9 no report while driving", {30'd0, perr_n, serr_pull}, 32'h2);
        chk("R9 no status while driving", {30'd0, status}, 32'd0);
    endtask

    task automatic t_injections();
        for (int en = 0; en < 4; en++) begin
            logic rp, se;
            rp = en[0]; se = en[1];
            for (int f = 1; f < 4; f++) begin
                rx_phase("R3 R4 R5 data", 32'hA5C3_0F12, 4'h6, 1'b0, f, (f == 1) ? 31 : 3,
                         rp, se, rp, 1'b0, 2'b01);
                rx_phase("R5 R6 R7 addr", 32'h0000_1000, 4'hB, 1'b1, f, (f == 1) ? 0 : 1,
                         rp, se, 1'b0, se, {se, 1'b1});
            end
        end
    endtask

    task automatic t_clean();
        rx_phase("R11 clean data", 32'hFFFF_FFFF, 4'hF, 1'b0, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
        rx_phase("R11 clean addr", 32'h1234_5678, 4'h2, 1'b1, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_ignored_invalid();
        // R9: phase_vld=0 with wrong parity is not checked
        @(negedge clk);
        cmd_par_resp = 1'b1; cmd_serr_en = 1'b1;
        ad_in = 32'h1; cbe_in = 4'h0; phase_vld = 1'b0;
        @(negedge clk); par_in = 1'b0;
        @(negedge clk);
        chk("R9 invalid phase no report", {30'd0, perr_n, serr_pull}, 32'h2);
        chk("R9 invalid phase no status", {30'd0, status}, 32'd0);
    endtask

    task automatic t_w1c();
        // Set then selective clear
        rx_phase("R8 setup", 32'h0, 4'h0, 1'b1, 3, 0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11);
        rx_phase("R8 setup2", 32'h0, 4'h1, 1'b1, 1, 5, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11);
        // rx_phase cleared; rebuild state 11 and clear only bit 0
        @(negedge clk);
        ad_in = 32'h3; cbe_in = 4'h0; phase_vld = 1'b1; phase_is_addr = 1'b1;
        @(negedge clk);
        phase_vld = 1'b0; phase_is_addr = 1'b0; par_in = 1'b1;
        // collision: clear strobe in the same clock the error is recorded
        stat_wr = 1'b1; stat_wdata = 2'b11;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = 2'b00;
        chk("R8 set wins over clear", {30'd0, status}, 32'h3);
        stat_wr = 1'b1; stat_wdata = 2'b01;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = 2'b00;
        chk("R8 clear bit0 only", {30'd0, status}, 32'h2);
        @(negedge clk);
        chk("R8 sticky hold", {30'd0, status}, 32'h2);
        clear_status();
        chk("R8 cleared", {30'd0, status}, 32'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        cmd_par_resp = 1'b1;
        ad_in = 32'h1; cbe_in = 4'h0; phase_vld = 1'b1; phase_is_addr = 1'b0;
        @(negedge clk);
        par_in = 1'b0;          // wrong for first (expects 1)
        ad_in = 32'h3;          // second phase, expects 0
        @(negedge clk);
        phase_vld = 1'b0;
        par_in = 1'b1;          // wrong for second
        chk("R3 back-to-back first", {31'd0, perr_n}, 32'd0);
        @(negedge clk);
        chk("R3 back-to-back second", {31'd0, perr_n}, 32'd0);
        @(negedge clk);
        chk("R3 back-to-back end", {31'd0, perr_n}, 32'd1);
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_generate(32'h8000_0000, 4'h0);
        t_generate(32'hDEAD_BEEF, 4'hC);
        t_generate(32'h0000_0000, 4'hF);
        t_ignored_invalid();
        t_clean();
        t_injections();
        t_w1c();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule